// File: doc/BRIEF.md
# Two-Level Longest-Prefix Route Lookup

This block turns a destination address into a next-hop code using two tables held inside the block. The upper bits of the address select one entry of a directly indexed first table. That entry either carries the next-hop itself or names a block of the second table. In the second case, the low address bits select one entry inside that block, and that entry carries the next-hop. Software expands its prefixes into the tables through two write ports. It places every route of up to the upper-field width in the first table. A longer route turns its first-table entry into a pointer to a block that covers every value of the low field.

A lookup is accepted every cycle. Each request produces exactly one result, in request order, two cycles later. A result resolved by the first table alone is held back so that it leaves at the same latency as an indirect result. An address that reaches an entry with no route returns the reserved code of all ones. The default widths are reduced for simulation: a 14-bit address split 10/4, 8-bit next-hop codes and 16 second-table blocks.

Top module: `lpm_route_lookup`

## Requirements
- R1: The upper HI_W address bits index the first table. For an indirect entry, the second table is indexed by {block index, low LO_W address bits}, with the block index in the high bits.
- R2: When the addressed first-table entry holds a route and its pointer bit is 0, the result is the low NH_W bits of that entry's payload.
- R3: When the addressed first-table entry holds a route and its pointer bit is 1, its low BLK_W payload bits pick the second-table block. The result is the next-hop of the selected second-table entry.
- R4: done_o is high in exactly the one cycle that follows the second rising clock edge after a request is sampled. Back-to-back requests give back-to-back results in request order.
- R5: A lookup that reaches an entry with no route returns all ones (8'hFF at the default width). This applies to a first-table entry, or to a second-table entry on the indirect path. An entry has no route if it was never written or if it was last written with its valid bit at 0.
- R6: A table write sampled on the same clock edge as a read of that table returns the previous contents to the lookup in flight. The new contents apply from the next read onward.
- R7: After reset, done_o and nh_o are 0 and every entry of both tables has no route.
- R8: nh_o keeps its last result in every cycle in which done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request |
| req_addr_i | input | ADDR_W | Destination address |
| t1_we_i | input | 1 | First-table write strobe |
| t1_idx_i | input | HI_W | First-table entry index |
| t1_valid_i | input | 1 | Entry holds a route |
| t1_ptr_i | input | 1 | 0: payload is next-hop, 1: payload is block index |
| t1_pay_i | input | PAY_W | Entry payload |
| t2_we_i | input | 1 | Second-table write strobe |
| t2_idx_i | input | BLK_W+LO_W | Second-table index {block, low field} |
| t2_valid_i | input | 1 | Entry holds a route |
| t2_nh_i | input | NH_W | Next-hop code |
| done_o | output | 1 | Result valid |
| nh_o | output | NH_W | Next-hop result |

## Verification
A route write and a lookup that reads the same entry can fall on the same clock edge, in either table. The first table is read on the edge that samples the request, and the second table is read one edge later. Directed steps place a first-table write on the request's own cycle, and a second-table write on the following cycle, both to the entry the lookup uses. The returned next-hop must be the old value, and the next request to that entry must return the new one. Random traffic concentrated on a few entries makes such collisions recur, with a bench model that applies writes only after each edge's reads.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int unsigned DEF_ADDR_W = 14;
  localparam int unsigned DEF_HI_W   = 10;
  localparam int unsigned DEF_LO_W   = 4;
  localparam int unsigned DEF_NH_W   = 8;
  localparam int unsigned DEF_BLK_W  = 4;

  typedef enum logic [1:0] {
    KIND_MISS     = 2'd0,
    KIND_DIRECT   = 2'd1,
    KIND_INDIRECT = 2'd2
  } lpm_kind_e;

  function automatic int unsigned max_w(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lpm_vram.sv
// Table with per-entry valid bit, synchronous read-first port.
module lpm_vram #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic          wvalid_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DEPTH-1:0] vld_q;
  logic [DW-1:0]    mem_q [DEPTH];
  logic             rvalid_q;
  logic [DW-1:0]    rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q    <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= vld_q[raddr_i];
      if (we_i) vld_q[waddr_i] <= wvalid_i;
    end
  end

  always_ff @(posedge clk_i) begin
    rdata_q <= mem_q[raddr_i];
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/lpm_resolve.sv
// Final select and result hold.
module lpm_resolve
  import lpm_pkg::*;
#(
  parameter int unsigned NH_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            s2_vld_i,
  input  lpm_kind_e       s2_kind_i,
  input  logic [NH_W-1:0] s2_nh_i,
  input  logic            t2_rvalid_i,
  input  logic [NH_W-1:0] t2_rdata_i,
  output logic            done_o,
  output logic [NH_W-1:0] nh_o
);
  localparam logic [NH_W-1:0] NO_ROUTE = '1;

  logic [NH_W-1:0] nh_new;
  logic [NH_W-1:0] hold_q;

  always_comb begin
    unique case (s2_kind_i)
      KIND_DIRECT:   nh_new = s2_nh_i;
      KIND_INDIRECT: nh_new = t2_rvalid_i ? t2_rdata_i : NO_ROUTE;
      default:       nh_new = NO_ROUTE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hold_q <= '0;
    else if (s2_vld_i) hold_q <= nh_new;
  end

  assign done_o = s2_vld_i;
  assign nh_o   = s2_vld_i ? nh_new : hold_q;
endmodule

// File: rtl/lpm_route_lookup.sv
module lpm_route_lookup
  import lpm_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned HI_W   = DEF_HI_W,
  parameter int unsigned LO_W   = DEF_LO_W,
  parameter int unsigned NH_W   = DEF_NH_W,
  parameter int unsigned BLK_W  = DEF_BLK_W,
  localparam int unsigned PAY_W = max_w(NH_W, BLK_W),
  localparam int unsigned T2_AW = BLK_W + LO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              t1_we_i,
  input  logic [HI_W-1:0]   t1_idx_i,
  input  logic              t1_valid_i,
  input  logic              t1_ptr_i,
  input  logic [PAY_W-1:0]  t1_pay_i,
  input  logic              t2_we_i,
  input  logic [T2_AW-1:0]  t2_idx_i,
  input  logic              t2_valid_i,
  input  logic [NH_W-1:0]   t2_nh_i,
  output logic              done_o,
  output logic [NH_W-1:0]   nh_o
);
  localparam int unsigned T1_DW = PAY_W + 1;

  if (HI_W + LO_W != ADDR_W) begin : g_bad_split
    $error("HI_W + LO_W must equal ADDR_W");
  end

  // stage 1: first-table read
  logic             s1_vld_q;
  logic [LO_W-1:0]  s1_lo_q;
  logic             t1_rvalid;
  logic [T1_DW-1:0] t1_rdata;
  logic             t1_rptr;
  logic [PAY_W-1:0] t1_rpay;

  lpm_vram #(.AW(HI_W), .DW(T1_DW)) u_t1 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (t1_we_i),
    .waddr_i  (t1_idx_i),
    .wvalid_i (t1_valid_i),
    .wdata_i  ({t1_ptr_i, t1_pay_i}),
    .raddr_i  (req_addr_i[ADDR_W-1 -: HI_W]),
    .rvalid_o (t1_rvalid),
    .rdata_o  (t1_rdata)
  );

  assign {t1_rptr, t1_rpay} = t1_rdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q <= 1'b0;
      s1_lo_q  <= '0;
    end else begin
      s1_vld_q <= req_valid_i;
      s1_lo_q  <= req_addr_i[LO_W-1:0];
    end
  end

  // stage 2: second-table read, direct hit delayed alongside
  lpm_kind_e       s1_kind;
  logic            s2_vld_q;
  lpm_kind_e       s2_kind_q;
  logic [NH_W-1:0] s2_nh_q;
  logic            t2_rvalid;
  logic [NH_W-1:0] t2_rdata;

  always_comb begin
    if (!t1_rvalid)   s1_kind = KIND_MISS;
    else if (t1_rptr) s1_kind = KIND_INDIRECT;
    else              s1_kind = KIND_DIRECT;
  end

  lpm_vram #(.AW(T2_AW), .DW(NH_W)) u_t2 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (t2_we_i),
    .waddr_i  (t2_idx_i),
    .wvalid_i (t2_valid_i),
    .wdata_i  (t2_nh_i),
    .raddr_i  ({t1_rpay[BLK_W-1:0], s1_lo_q}),
    .rvalid_o (t2_rvalid),
    .rdata_o  (t2_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld_q  <= 1'b0;
      s2_kind_q <= KIND_MISS;
      s2_nh_q   <= '0;
    end else begin
      s2_vld_q  <= s1_vld_q;
      s2_kind_q <= s1_kind;
      s2_nh_q   <= t1_rpay[NH_W-1:0];
    end
  end

  lpm_resolve #(.NH_W(NH_W)) u_res (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .s2_vld_i    (s2_vld_q),
    .s2_kind_i   (s2_kind_q),
    .s2_nh_i     (s2_nh_q),
    .t2_rvalid_i (t2_rvalid),
    .t2_rdata_i  (t2_rdata),
    .done_o      (done_o),
    .nh_o        (nh_o)
  );
endmodule

// File: rtl/lpm_route_lookup_chk.sv
module lpm_route_lookup_chk #(
  parameter int unsigned NH_W  = 8,
  parameter int unsigned PAY_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             done_o,
  input logic [NH_W-1:0]  nh_o,
  input logic             s1_vld,
  input logic             t1_rvalid,
  input logic             t1_rptr,
  input logic [PAY_W-1:0] t1_rpay
);
  logic v1_q, v2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= req_valid_i;
      v2_q <= v1_q;
    end
  end

  // R4
  done_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == v2_q);

  // R8
  nh_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(nh_o));

  // R2
  direct_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_vld && t1_rvalid && !t1_rptr) |=> (nh_o == $past(t1_rpay[NH_W-1:0])));

  // R5
  t1_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_vld && !t1_rvalid) |=> (done_o && nh_o == {NH_W{1'b1}}));
endmodule

bind lpm_route_lookup lpm_route_lookup_chk #(.NH_W(NH_W), .PAY_W(PAY_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .done_o      (done_o),
  .nh_o        (nh_o),
  .s1_vld      (s1_vld_q),
  .t1_rvalid   (t1_rvalid),
  .t1_rptr     (t1_rptr),
  .t1_rpay     (t1_rpay)
);

// File: tb/sim_lpm_route_lookup.sv
`timescale 1ns/1ps
module sim_lpm_route_lookup;
  localparam int AW = 14, HW = 10, LW = 4, NW = 8, BW = 4, PW = 8;
  localparam logic [NW-1:0] NOR = '1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 0; logic [AW-1:0] req_addr_i = '0;
  logic t1_we_i = 0, t1_valid_i = 0, t1_ptr_i = 0;
  logic [HW-1:0] t1_idx_i = '0; logic [PW-1:0] t1_pay_i = '0;
  logic t2_we_i = 0, t2_valid_i = 0;
  logic [BW+LW-1:0] t2_idx_i = '0; logic [NW-1:0] t2_nh_i = '0;
  logic done_o; logic [NW-1:0] nh_o;

  always #2 clk_i = ~clk_i;

  lpm_route_lookup u0 (.*);

  int checks = 0, errors = 0;

  // bench model of the tables
  bit m1_v [1<<HW]; bit m1_p [1<<HW]; logic [PW-1:0] m1_d [1<<HW];
  bit m2_v [1<<(BW+LW)]; logic [NW-1:0] m2_d [1<<(BW+LW)];
  bit s1v; bit s1_ev, s1_ep; logic [PW-1:0] s1_pay; logic [LW-1:0] s1_lo;
  bit exp_done = 0; logic [NW-1:0] exp_nh = '0; string exp_tag = "R7";

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    exp_done = s1v;
    if (s1v) begin
      if (!s1_ev) begin exp_nh = NOR; exp_tag = "R5"; end
      else if (!s1_ep) begin exp_nh = s1_pay[NW-1:0]; exp_tag = "R2"; end
      else begin
        logic [BW+LW-1:0] j = {s1_pay[BW-1:0], s1_lo};   // R1
        exp_nh = m2_v[j] ? m2_d[j] : NOR;
        exp_tag = m2_v[j] ? "R3" : "R5";
      end
    end
    s1v = req_valid_i;
    if (req_valid_i) begin
      int i = int'(req_addr_i[AW-1 -: HW]);
      s1_ev = m1_v[i]; s1_ep = m1_p[i]; s1_pay = m1_d[i]; s1_lo = req_addr_i[LW-1:0];
    end
    // writes land after the reads of the same edge (R6)
    if (t1_we_i) begin m1_v[t1_idx_i] = t1_valid_i; m1_p[t1_idx_i] = t1_ptr_i; m1_d[t1_idx_i] = t1_pay_i; end
    if (t2_we_i) begin m2_v[t2_idx_i] = t2_valid_i; m2_d[t2_idx_i] = t2_nh_i; end
  endtask

  // drive at negedge, model at posedge, compare at the following negedge
  task automatic step(bit rq, logic [AW-1:0] a,
                      bit w1, logic [HW-1:0] i1, bit v1, bit p1, logic [PW-1:0] d1,
                      bit w2, logic [BW+LW-1:0] i2, bit v2, logic [NW-1:0] d2);
    req_valid_i = rq; req_addr_i = a;
    t1_we_i = w1; t1_idx_i = i1; t1_valid_i = v1; t1_ptr_i = p1; t1_pay_i = d1;
    t2_we_i = w2; t2_idx_i = i2; t2_valid_i = v2; t2_nh_i = d2;
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    chk("R4 done", 32'(done_o), 32'(exp_done));
    if (exp_done) chk(exp_tag, 32'(nh_o), 32'(exp_nh));
    else          chk("R8 hold", 32'(nh_o), 32'(exp_nh));
  endtask

  task automatic idle(); step(0,'0, 0,'0,0,0,'0, 0,'0,0,'0); endtask
  task automatic look(logic [AW-1:0] a); step(1,a, 0,'0,0,0,'0, 0,'0,0,'0); endtask
  task automatic wr1(logic [HW-1:0] i, bit v, bit p, logic [PW-1:0] d); step(0,'0, 1,i,v,p,d, 0,'0,0,'0); endtask
  task automatic wr2(logic [BW+LW-1:0] i, bit v, logic [NW-1:0] d); step(0,'0, 0,'0,0,0,'0, 1,i,v,d); endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog R4 actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk_i);
    // R7: reset state
    chk("R7 done", 32'(done_o), 0);
    chk("R7 nh", 32'(nh_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R7/R5: fresh tables have no route
    look(14'h0155); idle(); idle();
    // R2: direct route, R4: back-to-back
    wr1(10'h003, 1, 0, 8'h3C);
    wr1(10'h004, 1, 0, 8'h41);
    look({10'h003, 4'h7}); look({10'h004, 4'h0}); look({10'h003, 4'hF}); idle(); idle();
    // R3/R1: pointer to block 5, entries at lo 2 and 9
    wr1(10'h010, 1, 1, 8'h05);
    wr2({4'h5, 4'h2}, 1, 8'hA2);
    wr2({4'h5, 4'h9}, 1, 8'hA9);
    look({10'h010, 4'h2}); look({10'h010, 4'h9});
    // R5: pointer path into an empty second-table slot
    look({10'h010, 4'h3}); idle(); idle();
    // R5: invalidated first-table entry
    wr1(10'h004, 0, 0, 8'h00); look({10'h004, 4'h1}); idle(); idle();
    // R6: first-table write on the request edge returns old, then new
    step(1, {10'h003, 4'h0}, 1, 10'h003, 1, 0, 8'h77, 0,'0,0,'0);
    look({10'h003, 4'h0}); idle(); idle();
    // R6: second-table write on the edge that reads it
    look({10'h010, 4'h2});
    step(0,'0, 0,'0,0,0,'0, 1, {4'h5, 4'h2}, 1, 8'hB2);
    look({10'h010, 4'h2}); idle(); idle();
    // R8: long gap keeps the last result
    repeat (5) idle();
    // random mix with collisions
    for (int n = 0; n < 4000; n++) begin
      bit rq = ($urandom % 4) != 0;
      logic [AW-1:0] a = {10'($urandom % 16), 4'($urandom)};
      bit w1 = ($urandom % 4) == 0;
      bit w2 = ($urandom % 3) == 0;
      logic [PW-1:0] d1;
      bit p1 = $urandom % 2;
      d1 = p1 ? PW'($urandom % 4) : PW'($urandom);
      step(rq, a, w1, 10'($urandom % 16), ($urandom % 8) != 0, p1, d1,
           w2, {4'($urandom % 4), 4'($urandom)}, ($urandom % 8) != 0, 8'($urandom));
    end
    idle(); idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule